// File: doc/BRIEF.md
# Three-Level Priority Interrupt Controller

This controller sits between a set of interrupt vector slots and a processor core. Each slot collects one or more pending flags from peripherals, has its own enable bit and a programmed priority code, and maps to a fixed vector address. Every cycle the controller picks the strongest active slot. It offers that slot to the core only if the slot's level is strictly above the level now in service.

An offer is registered and held stable until the core acknowledges it. On acknowledge, the offered level becomes the level in service and is remembered on a nesting record. A return strobe ends the innermost service and restores the level that was interrupted. Slots differ in which levels they may take: the first slots may be low or highest, and the rest may be low or high. Any code a slot may not take falls back to low.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, irq_req is 0 and cur_lvl is 0. Level values on irq_lvl and cur_lvl are encoded 0 = nothing in service, 1 = low, 2 = high, 3 = highest.
- R2: A slot is active when its slot_en bit is 1 and at least one of its flags is set. Flags for slot i are src_pend bits [2i+1:2i], and either flag alone is enough. A disabled slot never produces an offer. An offer appears on irq_req one clock edge after the conditions that cause it.
- R3: Among active slots, the one with the higher level wins.
- R4: Among active slots of equal level, the one with the lower index, and so the lower vector, wins.
- R5: The vector offered for slot i is 0x03 + 8*i, so slot 0 gives 0x03 and slot 9 gives 0x4B.
- R6: A slot is offered only if its level is strictly greater than cur_lvl. A slot at a level equal to or below cur_lvl is not offered.
- R7: A slot's 2-bit priority code sits at slot_code[2i+1:2i] and is read as 00 = low, 01 = high, 10 = highest. Slots 0 and 1 take code 10 as highest, and every other code as low. Slots 2 and above take code 01 as high, and every other code as low.
- R8: While irq_req is 1 and irq_ack is 0, irq_vec and irq_lvl stay unchanged, whatever the inputs do.
- R9: An irq_ack sampled while irq_req is 1 clears irq_req, and cur_lvl takes the offered level at the same edge.
- R10: An irq_ret strobe restores cur_lvl to the level that was in service before the innermost acknowledge. An irq_ret with nothing in service has no effect.
- R11: An irq_ack and an irq_ret in the same cycle end the innermost service and enter the newly acknowledged level. A later irq_ret then returns to the level below the ended one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_pend | input | 20 | Pending flags, two per slot |
| slot_en | input | 10 | Per-slot enable |
| slot_code | input | 20 | Per-slot 2-bit priority code |
| irq_ack | input | 1 | Core accepts the current offer |
| irq_ret | input | 1 | Core returns from the innermost service |
| irq_req | output | 1 | An offer is pending |
| irq_vec | output | 8 | Vector address of the offer |
| irq_lvl | output | 2 | Level of the offer |
| cur_lvl | output | 2 | Level now in service |

## Verification
The hardest case to reach is a full three-deep nest followed by unwinding, because each deeper level can only be entered through an acknowledged offer at a strictly higher level. The stimulus builds the nest one step at a time: it acknowledges a low slot, then a high slot, then a highest slot, and checks between steps that a still-pending equal-level slot stays silent. It then clears all flags and returns once per level, plus one extra return that must have no effect. A separate sequence lines up an acknowledge and a return in the same cycle to show that the ended level is dropped from the nesting record.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  // Internal rank: 0 = none, 1 = low, 2 = high, 3 = highest
  localparam logic [1:0] RANK_NONE = 2'd0;
  localparam logic [1:0] RANK_LOW  = 2'd1;
  localparam logic [1:0] RANK_HIGH = 2'd2;
  localparam logic [1:0] RANK_TOP  = 2'd3;

  // Programmed priority codes
  localparam logic [1:0] CODE_HIGH = 2'b01;
  localparam logic [1:0] CODE_TOP  = 2'b10;

  function automatic logic [2:0] rank_bit(input logic [1:0] r);
    case (r)
      RANK_LOW:  rank_bit = 3'b001;
      RANK_HIGH: rank_bit = 3'b010;
      RANK_TOP:  rank_bit = 3'b100;
      default:   rank_bit = 3'b000;
    endcase
  endfunction
endpackage

// File: rtl/irq_slot_map.sv
module irq_slot_map
  import irq_prio_pkg::*;
#(
  parameter int NUM_SLOTS     = 10,
  parameter int SRCS_PER_SLOT = 2,
  parameter int X_SLOTS       = 2
) (
  input  logic [NUM_SLOTS*SRCS_PER_SLOT-1:0] src_pend,
  input  logic [NUM_SLOTS-1:0]               slot_en,
  input  logic [2*NUM_SLOTS-1:0]             slot_code,
  output logic [NUM_SLOTS-1:0][1:0]          slot_rank
);
  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    logic       active;
    logic [1:0] code;
    logic [1:0] legal;

    assign active = slot_en[g] & (|src_pend[g*SRCS_PER_SLOT +: SRCS_PER_SLOT]);
    assign code   = slot_code[2*g +: 2];

    if (g < X_SLOTS) begin : g_top_capable
      assign legal = (code == CODE_TOP) ? RANK_TOP : RANK_LOW;
    end else begin : g_high_capable
      assign legal = (code == CODE_HIGH) ? RANK_HIGH : RANK_LOW;
    end

    assign slot_rank[g] = active ? legal : RANK_NONE;
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_prio_pkg::*;
#(
  parameter int NUM_SLOTS = 10,
  localparam int IDX_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic [NUM_SLOTS-1:0][1:0] slot_rank,
  input  logic [1:0]                floor_rank,
  output logic                      win_valid,
  output logic [IDX_W-1:0]          win_idx,
  output logic [1:0]                win_rank
);
  logic [1:0]       best_rank;
  logic [IDX_W-1:0] best_idx;

  // Ascending scan with strict compare: the lowest index keeps a tie.
  always_comb begin
    best_rank = RANK_NONE;
    best_idx  = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (slot_rank[i] > best_rank) begin
        best_rank = slot_rank[i];
        best_idx  = IDX_W'(i);
      end
    end
  end

  assign win_valid = best_rank > floor_rank;
  assign win_idx   = best_idx;
  assign win_rank  = best_rank;

  // R3/R4: no slot is stronger than the winner, and none of equal rank sits below it
  always_comb begin
    for (int k = 0; k < NUM_SLOTS; k++) begin
      a_winner_r3: assert (!win_valid || slot_rank[k] <= win_rank ||
                           $isunknown(slot_rank[k]));
      if (win_valid && (k < int'(win_idx))) begin
        a_tie_low_r4: assert (slot_rank[k] != win_rank || $isunknown(slot_rank[k]));
      end
    end
  end
endmodule

// File: rtl/irq_level_stack.sv
module irq_level_stack
  import irq_prio_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push,
  input  logic [1:0] push_rank,
  input  logic       pop,
  output logic [1:0] cur_rank
);
  // Levels nest strictly upward, so the nesting record is one bit per level.
  logic [2:0] mask_q;
  logic [2:0] mask_n;
  logic [2:0] top_bit;
  logic       mask_en;

  always_comb begin
    if (mask_q[2])      top_bit = 3'b100;
    else if (mask_q[1]) top_bit = 3'b010;
    else                top_bit = {2'b00, mask_q[0]};
  end

  always_comb begin
    if (mask_q[2])      cur_rank = RANK_TOP;
    else if (mask_q[1]) cur_rank = RANK_HIGH;
    else if (mask_q[0]) cur_rank = RANK_LOW;
    else                cur_rank = RANK_NONE;
  end

  assign mask_en = push | pop;

  always_comb begin
    mask_n = mask_q;
    if (pop)  mask_n = mask_n & ~top_bit;
    if (push) mask_n = mask_n | rank_bit(push_rank);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= 3'b000;
    else if (mask_en) mask_q <= mask_n;
  end

  p_ret_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && mask_q == 3'b000) |=> (mask_q == 3'b000));

  p_ret_one_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && mask_q != 3'b000) |=>
      ($countones(mask_q) == $countones($past(mask_q)) - 1));

  p_push_above_r11: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (push_rank > cur_rank));
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int NUM_SLOTS     = 10,
  parameter int SRCS_PER_SLOT = 2,
  parameter int X_SLOTS       = 2,
  parameter int VEC_W         = 8,
  parameter int VEC_BASE      = 3,
  parameter int VEC_STEP      = 8,
  localparam int IDX_W        = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int SRC_W        = NUM_SLOTS * SRCS_PER_SLOT
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [SRC_W-1:0]       src_pend,
  input  logic [NUM_SLOTS-1:0]   slot_en,
  input  logic [2*NUM_SLOTS-1:0] slot_code,
  input  logic                   irq_ack,
  input  logic                   irq_ret,
  output logic                   irq_req,
  output logic [VEC_W-1:0]       irq_vec,
  output logic [1:0]             irq_lvl,
  output logic [1:0]             cur_lvl
);
  logic [NUM_SLOTS-1:0][1:0] slot_rank;
  logic                      win_valid;
  logic [IDX_W-1:0]          win_idx;
  logic [1:0]                win_rank;
  logic [VEC_W-1:0]          win_vec;
  logic [1:0]                cur_rank;

  logic             req_q, req_n, req_en;
  logic [VEC_W-1:0] vec_q;
  logic [1:0]       rank_q;
  logic             ack_fire, offer_load;

  irq_slot_map #(
    .NUM_SLOTS     (NUM_SLOTS),
    .SRCS_PER_SLOT (SRCS_PER_SLOT),
    .X_SLOTS       (X_SLOTS)
  ) u_map (
    .src_pend  (src_pend),
    .slot_en   (slot_en),
    .slot_code (slot_code),
    .slot_rank (slot_rank)
  );

  irq_arbiter #(
    .NUM_SLOTS (NUM_SLOTS)
  ) u_arb (
    .slot_rank  (slot_rank),
    .floor_rank (cur_rank),
    .win_valid  (win_valid),
    .win_idx    (win_idx),
    .win_rank   (win_rank)
  );

  irq_level_stack u_stack (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (ack_fire),
    .push_rank (rank_q),
    .pop       (irq_ret),
    .cur_rank  (cur_rank)
  );

  assign win_vec = VEC_W'(VEC_BASE) + VEC_W'(win_idx) * VEC_W'(VEC_STEP);

  // Offer handshake: load when idle, clear on acknowledge
  always_comb begin
    ack_fire   = req_q & irq_ack;
    offer_load = ~req_q & win_valid;
    req_en     = ack_fire | offer_load;
    req_n      = offer_load;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      req_q <= 1'b0;
    else if (req_en) req_q <= req_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q  <= '0;
      rank_q <= RANK_NONE;
    end else if (offer_load) begin
      vec_q  <= win_vec;
      rank_q <= win_rank;
    end
  end

  assign irq_req = req_q;
  assign irq_vec = vec_q;
  assign irq_lvl = rank_q;
  assign cur_lvl = cur_rank;

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !irq_ack) |=> (irq_req && $stable(irq_vec) && $stable(irq_lvl)));

  p_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && irq_ack) |=> (!irq_req && cur_lvl == $past(irq_lvl)));

  p_above_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_lvl > cur_lvl));
endmodule

// File: tb/irq_prio_ctrl_tb.sv
module irq_prio_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic [19:0] src_pend;
  logic [9:0]  slot_en;
  logic [19:0] slot_code;
  logic        irq_ack;
  logic        irq_ret;
  logic        irq_req;
  logic [7:0]  irq_vec;
  logic [1:0]  irq_lvl;
  logic [1:0]  cur_lvl;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  irq_prio_ctrl u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_pend  (src_pend),
    .slot_en   (slot_en),
    .slot_code (slot_code),
    .irq_ack   (irq_ack),
    .irq_ret   (irq_ret),
    .irq_req   (irq_req),
    .irq_vec   (irq_vec),
    .irq_lvl   (irq_lvl),
    .cur_lvl   (cur_lvl)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_reset();
    src_pend  = '0;
    slot_en   = '0;
    slot_code = '0;
    irq_ack   = 1'b0;
    irq_ret   = 1'b0;
    rst_n     = 1'b0;
    tick();
    tick();
    rst_n = 1'b1;
    tick();
  endtask

  // code: 0 low, 1 high, 2 highest; src selects which of the two flags
  task automatic set_slot(input int idx, input logic [1:0] code, input int src);
    slot_en[idx]           = 1'b1;
    slot_code[2*idx +: 2]  = code;
    src_pend[2*idx + src]  = 1'b1;
  endtask

  task automatic ack_now();
    irq_ack = 1'b1;
    tick();
    irq_ack = 1'b0;
  endtask

  task automatic ret_now();
    irq_ret = 1'b1;
    tick();
    irq_ret = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 req after reset", int'(irq_req), 0);
    chk("R1 cur after reset", int'(cur_lvl), 0);
  endtask

  task automatic t_basic();
    do_reset();
    src_pend[13] = 1'b1;             // slot 6 flag, slot disabled
    slot_code[13:12] = 2'b01;
    tick();
    tick();
    chk("R2 disabled slot silent", int'(irq_req), 0);
    set_slot(4, 2'b01, 1);           // second flag of slot 4
    tick();
    chk("R2 req one edge later", int'(irq_req), 1);
    chk("R5 vector slot 4", int'(irq_vec), 'h23);
    chk("R7 level high slot 4", int'(irq_lvl), 2);
    do_reset();
    set_slot(9, 2'b00, 0);
    tick();
    chk("R5 vector slot 9", int'(irq_vec), 'h4B);
  endtask

  task automatic t_level();
    do_reset();
    set_slot(2, 2'b00, 0);
    set_slot(7, 2'b01, 0);
    tick();
    chk("R3 high beats low vec", int'(irq_vec), 'h3B);
    do_reset();
    set_slot(7, 2'b01, 0);
    set_slot(0, 2'b10, 1);
    tick();
    chk("R3 highest wins vec", int'(irq_vec), 'h03);
    chk("R3 highest wins lvl", int'(irq_lvl), 3);
  endtask

  task automatic t_tie();
    do_reset();
    set_slot(8, 2'b01, 0);
    set_slot(3, 2'b01, 1);
    tick();
    chk("R4 tie high lowest vec", int'(irq_vec), 'h1B);
    do_reset();
    set_slot(9, 2'b00, 0);
    set_slot(6, 2'b00, 0);
    tick();
    chk("R4 tie low lowest vec", int'(irq_vec), 'h33);
  endtask

  task automatic t_legal();
    do_reset();
    set_slot(1, 2'b01, 0);
    tick();
    chk("R7 high on slot 1 is low", int'(irq_lvl), 1);
    chk("R5 vector slot 1", int'(irq_vec), 'h0B);
    do_reset();
    set_slot(5, 2'b10, 0);
    tick();
    chk("R7 highest on slot 5 is low", int'(irq_lvl), 1);
    do_reset();
    set_slot(2, 2'b11, 0);
    tick();
    chk("R7 code 11 is low", int'(irq_lvl), 1);
    do_reset();
    set_slot(0, 2'b10, 0);
    tick();
    chk("R7 highest on slot 0", int'(irq_lvl), 3);
  endtask

  task automatic t_hold();
    do_reset();
    set_slot(5, 2'b01, 0);
    tick();
    chk("R8 first offer vec", int'(irq_vec), 'h2B);
    slot_en[5] = 1'b0;
    set_slot(0, 2'b10, 0);
    tick();
    tick();
    tick();
    chk("R8 held req", int'(irq_req), 1);
    chk("R8 held vec", int'(irq_vec), 'h2B);
    chk("R8 held lvl", int'(irq_lvl), 2);
    ack_now();
    chk("R9 req cleared", int'(irq_req), 0);
    chk("R9 cur takes level", int'(cur_lvl), 2);
    tick();
    chk("R6 highest preempts high", int'(irq_vec), 'h03);
  endtask

  task automatic t_nest();
    do_reset();
    set_slot(3, 2'b00, 0);
    tick();
    ack_now();
    chk("R9 cur low", int'(cur_lvl), 1);
    tick();
    tick();
    chk("R6 equal level blocked", int'(irq_req), 0);
    set_slot(6, 2'b01, 1);
    tick();
    chk("R6 higher offered vec", int'(irq_vec), 'h33);
    ack_now();
    chk("R9 cur high", int'(cur_lvl), 2);
    set_slot(0, 2'b10, 0);
    tick();
    chk("R6 highest offered lvl", int'(irq_lvl), 3);
    ack_now();
    chk("R9 cur highest", int'(cur_lvl), 3);
    src_pend = '0;
    ret_now();
    chk("R10 back to high", int'(cur_lvl), 2);
    ret_now();
    chk("R10 back to low", int'(cur_lvl), 1);
    ret_now();
    chk("R10 back to none", int'(cur_lvl), 0);
    ret_now();
    chk("R10 extra ret ignored", int'(cur_lvl), 0);
    chk("R10 no offer after ret", int'(irq_req), 0);
  endtask

  task automatic t_ackret();
    do_reset();
    set_slot(3, 2'b00, 0);
    tick();
    ack_now();
    set_slot(6, 2'b01, 0);
    tick();
    chk("R11 high offered", int'(irq_vec), 'h33);
    irq_ack = 1'b1;
    irq_ret = 1'b1;
    tick();
    irq_ack = 1'b0;
    irq_ret = 1'b0;
    chk("R11 cur high after ack+ret", int'(cur_lvl), 2);
    src_pend = '0;
    ret_now();
    chk("R11 low level was ended", int'(cur_lvl), 0);
  endtask

  initial begin
    rst_n = 1'b0;
    t_reset();
    t_basic();
    t_level();
    t_tie();
    t_legal();
    t_hold();
    t_nest();
    t_ackret();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule